// File: doc/BRIEF.md
# Sync-Request Window Calibration Engine

This block measures where a synchronization request lands relative to the next rising edge of a fast reference clock, and from that picks a delay offset for the request that leaves the most setup and hold margin. An ideal tapped delay line samples the reference clock along the request path. It delivers a capture vector in two halves, a left half and a right half. The engine latches that vector when the request rises. It waits until the request has been held long enough for the capture to settle, then decodes the vector and reports three results: the distance in taps to the first clock edge, that distance converted to picoseconds, and a recommended offset code.

A calibration run is started by pulsing the clear input high and then low. The engine then waits until it sees the request low, and takes the next rising edge of the request as the measurement. The step size of the delay line is chosen by a two-bit select. The results stay on the outputs, flagged valid, until the next clear. If the vector holds no usable edge, a status flag is raised and the results read zero.

Top module: `wcal_engine`

## Requirements
- R1: After synchronous reset, valid and no_edge are low and edge_taps, offset_code and edge_ps are zero. No capture happens until a clear pulse has been seen.
- R2: After clear falls, the engine first needs the request sampled low. If the request is still high when clear falls, it is ignored until it has gone low and risen again.
- R3: The capture is taken on the first edge that samples the request high. valid rises HOLD_CYC clock edges later, provided the request is sampled high on every edge in between. If it is sampled low earlier, no result is produced and the next rising edge starts a fresh capture.
- R4: The capture vector is {win_left, win_right}. Bit 0 is bit 0 of win_right and is the earliest tap. edge_taps is the number of zero bits between the lowest set bit and the lower index of the first pair of adjacent set bits at or above it.
- R5: edge_ps equals edge_taps times the step delay chosen by dly_sel at the capture edge. Codes 0, 1, 2 and 3 give 28, 15, 11 and 8 ps.
- R6: The period P is the distance from the start of that pair to the next 0-to-1 transition above it. offset_code is (edge_taps + P - floor(P/2)) mod P, which is the lowest offset that centres the request between clock edges. If there is no such transition, offset_code is floor(edge_taps/2).
- R7: If the vector has no set bit, or no adjacent pair of set bits, no_edge is 1 with valid, and edge_taps, offset_code and edge_ps are 0.
- R8: The results and valid hold until clear. A high clear drops valid on the next edge.
- R9: While valid, further request edges and changes to the vector or dly_sel leave all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Clear; a high-then-low pulse arms a run |
| req | input | 1 | Synchronization request |
| dly_sel | input | 2 | Delay step select |
| win_left | input | TAPS/2 | Upper half of the capture vector |
| win_right | input | TAPS/2 | Lower half of the capture vector (bit 0 earliest) |
| valid | output | 1 | Results valid |
| no_edge | output | 1 | No usable clock edge in the capture |
| edge_taps | output | IDX_W | Zero taps to the first clock edge |
| offset_code | output | IDX_W | Recommended delay offset |
| edge_ps | output | PS_W | Distance to the edge in picoseconds |

## Verification
The assertions check on every cycle that valid persists until clear, that clear drops it, that the results stay frozen while valid, that no_edge only appears with valid and forces zero results, and that valid only rises after the request has been held high. Only the bench scenarios can show that the decoded distance, period and offset match the vector across a sweep of edge phases, periods and step selects. The same holds for an early drop of the request yielding nothing, and for a request still high at clear release being ignored.

// File: rtl/wcal_pkg.sv
// Shared types and the step-delay table for the window calibration engine.
// Assumes a two-bit step select; delays are in picoseconds.
package wcal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_WAIT_LOW,
        ST_WAIT_RISE,
        ST_HOLD,
        ST_DONE
    } wcal_state_t;

    // Step delay in ps for each select code.
    function automatic logic [4:0] step_ps(input logic [1:0] sel);
        case (sel)
            2'd0:    step_ps = 5'd28;
            2'd1:    step_ps = 5'd15;
            2'd2:    step_ps = 5'd11;
            default: step_ps = 5'd8;
        endcase
    endfunction

endpackage

// File: rtl/wcal_tap_model.sv
// Ideal delay-line model for stimulus. Tap 0 always sees the request (1).
// Tap i>0 shows the reference clock level: low for the first edge_pos taps,
// then high for per/2 taps and low for the rest of each per-tap period.
// Assumes per >= 2; per == 0 yields an all-low clock.
module wcal_tap_model #(
    parameter int TAPS  = 32,
    parameter int IDX_W = $clog2(TAPS + 1)
) (
    input  logic [IDX_W-1:0] edge_pos,
    input  logic [IDX_W-1:0] per,
    output logic [TAPS-1:0]  win
);
    // Build the sampled clock pattern across all taps.
    always_comb begin
        win    = '0;
        win[0] = 1'b1;
        for (int i = 1; i < TAPS; i++) begin
            if (per != '0 && (i - 1) >= int'(edge_pos))
                win[i] = (((i - 1 - int'(edge_pos)) % int'(per)) < (int'(per) / 2));
        end
    end
endmodule

// File: rtl/wcal_seq.sv
// Run sequencer: clear pulse, wait for request low, capture on rise,
// qualify by hold time, then hold results until the next clear.
// Assumes req is already synchronous to clk.
module wcal_seq
    import wcal_pkg::*;
#(
    parameter int TAPS     = 32,
    parameter int HOLD_CYC = 4,
    localparam int CNT_W   = $clog2(HOLD_CYC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            req,
    input  logic [1:0]      dly_sel,
    input  logic [TAPS-1:0] win,
    output logic [TAPS-1:0] cap_vec,
    output logic [1:0]      cap_sel,
    output logic            load,
    output logic            valid
);
    wcal_state_t      state;
    logic [CNT_W-1:0] hold_cnt;

    assign load = (state == ST_HOLD) && req && (hold_cnt == CNT_W'(HOLD_CYC - 1));

    // State transitions, hold counting and capture latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            hold_cnt <= '0;
            cap_vec  <= '0;
            cap_sel  <= '0;
            valid    <= 1'b0;
        end else if (clr) begin
            state <= ST_CLR;
            valid <= 1'b0;
        end else begin
            case (state)
                ST_CLR:       state <= ST_WAIT_LOW;
                ST_WAIT_LOW:  if (!req) state <= ST_WAIT_RISE;
                ST_WAIT_RISE: if (req) begin
                    state    <= ST_HOLD;
                    hold_cnt <= '0;
                    cap_vec  <= win;
                    cap_sel  <= dly_sel;
                end
                ST_HOLD: begin
                    if (!req)      state <= ST_WAIT_RISE;
                    else if (load) begin
                        state <= ST_DONE;
                        valid <= 1'b1;
                    end else       hold_cnt <= hold_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wcal_decode.sv
// Combinational decode of a capture vector: zero count between the lowest
// set bit and the first adjacent pair, and the period to the next rising
// transition. Assumes bit 0 is the earliest tap.
module wcal_decode #(
    parameter int TAPS  = 32,
    parameter int IDX_W = $clog2(TAPS + 1)
) (
    input  logic [TAPS-1:0]  vec,
    output logic             found,
    output logic [IDX_W-1:0] zeros,
    output logic [IDX_W-1:0] period
);
    logic [TAPS-1:0] pair_v;
    logic [TAPS-1:0] rise_v;

    // Per-tap markers for adjacent pairs and 0-to-1 transitions.
    for (genvar g = 0; g < TAPS; g++) begin : g_mark
        if (g == TAPS - 1) begin : g_top
            assign pair_v[g] = 1'b0;
        end else begin : g_mid
            assign pair_v[g] = vec[g] & vec[g+1];
        end
        if (g == 0) begin : g_low
            assign rise_v[g] = 1'b0;
        end else begin : g_up
            assign rise_v[g] = ~vec[g-1] & vec[g];
        end
    end

    logic             lsb_f, rise_f;
    logic [IDX_W-1:0] pair_i, rise_i;

    // Single scan: lowest set bit, then pair, then next rising transition.
    always_comb begin
        lsb_f  = 1'b0;
        found  = 1'b0;
        rise_f = 1'b0;
        zeros  = '0;
        pair_i = '0;
        rise_i = '0;
        for (int i = 0; i < TAPS; i++) begin
            if (!lsb_f) begin
                if (vec[i]) begin
                    lsb_f = 1'b1;
                    if (pair_v[i]) begin
                        found  = 1'b1;
                        pair_i = IDX_W'(i);
                    end
                end
            end else if (!found) begin
                if (pair_v[i]) begin
                    found  = 1'b1;
                    pair_i = IDX_W'(i);
                end else if (!vec[i]) begin
                    zeros = zeros + 1'b1;
                end
            end else if (!rise_f && rise_v[i]) begin
                rise_f = 1'b1;
                rise_i = IDX_W'(i);
            end
        end
        period = rise_f ? (rise_i - pair_i) : '0;
    end
endmodule

// File: rtl/wcal_offset.sv
// Offset choice and picosecond conversion. The offset centres the delayed
// request between clock edges and is the lowest such value (mod period).
// Assumes zeros and period come from wcal_decode.
module wcal_offset
    import wcal_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int PS_W  = 12
) (
    input  logic [IDX_W-1:0] zeros,
    input  logic [IDX_W-1:0] period,
    input  logic [1:0]       sel,
    output logic [IDX_W-1:0] offset,
    output logic [PS_W-1:0]  dist_ps
);
    logic [IDX_W:0] shifted;

    // Offset arithmetic, with a half-distance fallback when no period is seen.
    always_comb begin
        shifted = {1'b0, zeros} + {1'b0, period} - {2'b0, period[IDX_W-1:1]};
        if (period == '0) offset = zeros >> 1;
        else              offset = IDX_W'(shifted % {1'b0, period});
        dist_ps = PS_W'(zeros) * PS_W'(step_ps(sel));
    end
endmodule

// File: rtl/wcal_engine.sv
// Top of the sync-request window calibration engine. Captures the tap
// vector on a qualified request rise, decodes it and registers results.
// Assumes synchronous inputs and an ideal tap line feeding win_left/right.
module wcal_engine #(
    parameter int TAPS     = 32,
    parameter int HOLD_CYC = 4,
    parameter int PS_W     = 12,
    localparam int HALF    = TAPS / 2,
    localparam int IDX_W   = $clog2(TAPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             req,
    input  logic [1:0]       dly_sel,
    input  logic [HALF-1:0]  win_left,
    input  logic [HALF-1:0]  win_right,
    output logic             valid,
    output logic             no_edge,
    output logic [IDX_W-1:0] edge_taps,
    output logic [IDX_W-1:0] offset_code,
    output logic [PS_W-1:0]  edge_ps
);
    logic [TAPS-1:0]  cap_vec;
    logic [1:0]       cap_sel;
    logic             load;
    logic             found;
    logic [IDX_W-1:0] zeros, period, ofs;
    logic [PS_W-1:0]  dist_ps;

    wcal_seq #(.TAPS(TAPS), .HOLD_CYC(HOLD_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(clr), .req(req), .dly_sel(dly_sel),
        .win({win_left, win_right}), .cap_vec(cap_vec), .cap_sel(cap_sel),
        .load(load), .valid(valid)
    );

    wcal_decode #(.TAPS(TAPS), .IDX_W(IDX_W)) u_dec (
        .vec(cap_vec), .found(found), .zeros(zeros), .period(period)
    );

    wcal_offset #(.IDX_W(IDX_W), .PS_W(PS_W)) u_ofs (
        .zeros(zeros), .period(period), .sel(cap_sel),
        .offset(ofs), .dist_ps(dist_ps)
    );

    // Result registers: loaded once per run, zeroed by reset and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            no_edge     <= 1'b0;
            edge_taps   <= '0;
            offset_code <= '0;
            edge_ps     <= '0;
        end else if (load) begin
            no_edge     <= !found;
            edge_taps   <= found ? zeros   : '0;
            offset_code <= found ? ofs     : '0;
            edge_ps     <= found ? dist_ps : '0;
        end
    end
endmodule

// File: rtl/wcal_engine_chk.sv
// Cycle checks on the engine's ports; attached to every wcal_engine.
module wcal_engine_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             req,
    input logic             valid,
    input logic             no_edge,
    input logic [IDX_W-1:0] edge_taps,
    input logic [IDX_W-1:0] offset_code
);
    // R8
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !clr |=> valid);
    // R8
    clr_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !valid);
    // R9
    results_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !clr |=> $stable(edge_taps) && $stable(offset_code) && $stable(no_edge));
    // R7
    no_edge_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_edge |-> valid && edge_taps == '0 && offset_code == '0);
    // R3
    held_before_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(req) && $past(req, 2));
endmodule

bind wcal_engine wcal_engine_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .req(req), .valid(valid),
    .no_edge(no_edge), .edge_taps(edge_taps), .offset_code(offset_code)
);

// File: tb/wcal_engine_tb.sv
// Scoreboard bench: runs push expected results, a monitor pops on valid rise.
module wcal_engine_tb;
    localparam int TAPS  = 32;
    localparam int HALF  = TAPS / 2;
    localparam int HOLD  = 4;
    localparam int PS_W  = 12;
    localparam int IDX_W = $clog2(TAPS + 1);

    typedef struct packed {
        logic             ne;
        logic [IDX_W-1:0] taps;
        logic [IDX_W-1:0] ofs;
        logic [PS_W-1:0]  ps;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, req = 1'b0;
    logic [1:0]       dly_sel = '0;
    logic             use_model = 1'b1;
    logic [TAPS-1:0]  fixed_vec = '0;
    logic [IDX_W-1:0] e_pos = '0, e_per = 6'd8;
    logic [TAPS-1:0]  model_vec, vec;
    logic             valid, no_edge;
    logic [IDX_W-1:0] edge_taps, offset_code;
    logic [PS_W-1:0]  edge_ps;
    int               n_run = 0, n_fail = 0, cyc = 0;
    exp_t             q[$];

    always #5 clk = ~clk;

    assign vec = use_model ? model_vec : fixed_vec;

    wcal_tap_model #(.TAPS(TAPS), .IDX_W(IDX_W)) u_model (
        .edge_pos(e_pos), .per(e_per), .win(model_vec));

    wcal_engine #(.TAPS(TAPS), .HOLD_CYC(HOLD), .PS_W(PS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .req(req), .dly_sel(dly_sel),
        .win_left(vec[TAPS-1:HALF]), .win_right(vec[HALF-1:0]),
        .valid(valid), .no_edge(no_edge), .edge_taps(edge_taps),
        .offset_code(offset_code), .edge_ps(edge_ps));

    function automatic int step_of(input logic [1:0] s);
        return (s == 0) ? 28 : (s == 1) ? 15 : (s == 2) ? 11 : 8;
    endfunction

    // Expected result from the written requirements R4..R7.
    function automatic exp_t ref_dec(input logic [TAPS-1:0] v, input logic [1:0] s);
        exp_t r;
        int lsb = -1, pair = -1, rise = -1, z = 0, p, o;
        for (int i = 0; i < TAPS; i++) begin
            if (lsb < 0) begin
                if (v[i]) begin
                    lsb = i;
                    if (i < TAPS - 1 && v[i+1]) pair = i;
                end
            end else if (pair < 0) begin
                if (v[i] && i < TAPS - 1 && v[i+1]) pair = i;
                else if (!v[i]) z++;
            end else if (rise < 0 && i > 0 && !v[i-1] && v[i]) rise = i;
        end
        if (pair < 0) return '{ne: 1'b1, taps: '0, ofs: '0, ps: '0};
        p = (rise >= 0) ? rise - pair : 0;
        o = (p == 0) ? z / 2 : (z + p - p / 2) % p;
        r.ne = 1'b0; r.taps = IDX_W'(z); r.ofs = IDX_W'(o);
        r.ps = PS_W'(z * step_of(s));
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Clear pulse, then let the engine see request low.
    task automatic arm();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Rise the request, check valid timing (R3), push expected item.
    task automatic measure(input exp_t e);
        q.push_back(e);
        @(negedge clk) req = 1'b1;
        repeat (HOLD) @(negedge clk);
        check("R3 valid before hold elapsed", int'(valid), 0);
        @(negedge clk);
        check("R3 valid after hold", int'(valid), 1);
        req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pop and compare on each valid rise.
    logic valid_q = 1'b0;
    always @(negedge clk) begin
        if (valid && !valid_q) begin
            if (q.size() == 0) check("R3 unexpected result", 1, 0);
            else begin
                exp_t e;
                e = q.pop_front();
                check("R7 no_edge", int'(no_edge), int'(e.ne));
                check("R4 edge_taps", int'(edge_taps), int'(e.taps));
                check("R6 offset_code", int'(offset_code), int'(e.ofs));
                check("R5 edge_ps", int'(edge_ps), int'(e.ps));
            end
        end
        valid_q <= valid;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            check("watchdog", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 valid", int'(valid), 0);
        check("R1 no_edge", int'(no_edge), 0);
        check("R1 results", int'(edge_taps) + int'(offset_code) + int'(edge_ps), 0);
        // R1 no capture before a clear pulse
        req = 1'b1; repeat (HOLD + 3) @(negedge clk); req = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 no capture before clear", int'(valid), 0);

        // R4 R5 R6 sweep of edge phase, period and step select
        for (int p = 6; p <= 11; p += 5) begin
            for (int e = 0; e < 12; e++) begin
                use_model = 1'b1;
                e_pos = IDX_W'(e); e_per = IDX_W'(p); dly_sel = 2'(e);
                #1;
                arm();
                measure(ref_dec(vec, dly_sel));
            end
        end

        // R4 R6 hand-computed: taps 3, period 6, offset 0, 8 ps step
        use_model = 1'b0;
        fixed_vec = 32'b0000_0000_0000_0000_0000_0100_0111_0001;
        dly_sel = 2'd3; arm();
        measure('{ne: 1'b0, taps: 6'd3, ofs: 6'd0, ps: 12'd24});
        // R6 no rising transition after the pair: offset = floor(4/2)
        fixed_vec = 32'b0000_0000_0000_0000_0000_0000_0110_0001;
        dly_sel = 2'd1; arm();
        measure('{ne: 1'b0, taps: 6'd4, ofs: 6'd2, ps: 12'd60});
        // R7 empty vector and a vector with no adjacent pair
        fixed_vec = '0; arm();
        measure('{ne: 1'b1, taps: '0, ofs: '0, ps: '0});
        fixed_vec = 32'h0001_5004; arm();
        measure('{ne: 1'b1, taps: '0, ofs: '0, ps: '0});

        // R3 early drop gives nothing; next rise is measured
        use_model = 1'b1; e_pos = 6'd5; e_per = 6'd8; dly_sel = 2'd2;
        #1;
        arm();
        @(negedge clk) req = 1'b1;
        repeat (HOLD - 2) @(negedge clk);
        req = 1'b0;
        repeat (HOLD + 4) @(negedge clk);
        check("R3 no result after early drop", int'(valid), 0);
        measure(ref_dec(vec, dly_sel));

        // R2 request high when clear falls is ignored until low again
        e_pos = 6'd9; dly_sel = 2'd0; #1;
        @(negedge clk) begin clr = 1'b1; req = 1'b1; end
        @(negedge clk) clr = 1'b0;
        repeat (HOLD + 6) @(negedge clk);
        check("R2 high request at clear release ignored", int'(valid), 0);
        req = 1'b0; repeat (2) @(negedge clk);
        measure(ref_dec(vec, dly_sel));

        // R9 outputs frozen while valid
        begin
            int t0, o0, s0;
            t0 = int'(edge_taps); o0 = int'(offset_code); s0 = int'(edge_ps);
            e_pos = 6'd2; dly_sel = 2'd3;
            @(negedge clk) req = 1'b1;
            repeat (HOLD + 3) @(negedge clk);
            req = 1'b0; @(negedge clk);
            check("R9 edge_taps frozen", int'(edge_taps), t0);
            check("R9 offset frozen", int'(offset_code), o0);
            check("R9 edge_ps frozen", int'(edge_ps), s0);
            check("R9 valid kept", int'(valid), 1);
        end

        // R8 clear drops valid on next edge
        @(negedge clk) clr = 1'b1;
        @(negedge clk);
        check("R8 valid after clear", int'(valid), 0);
        check("R8 results after clear", int'(edge_taps) + int'(edge_ps), 0);
        clr = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 scoreboard drained", q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule